// File: doc/BRIEF.md
# DRAM Pattern Test and Geometry Detector

This block sits above a DRAM access sequencer and performs two jobs. On a test command it runs a write-then-read-back check of one byte address with a fixed series of eight bit patterns, stopping at the first mismatch and reporting which pattern failed and what came back. On a detect command it works out the module's geometry: how many multiplexed row/column address bits it uses and whether a second bank (second row strobe group) answers. It then derives the module's size in bytes from those two results.

Both jobs share one single-address test engine, so the sequencer never sees more than one access at a time. Each access is a request held with a write flag, a bank select, a row, a column and write data until the sequencer acknowledges it. A read's data arrives with that acknowledge. The width found by detection is kept and used to split the address of every later test command into row, column and bank.

Top module: `dram_geom_probe`

## Requirements
- R1: After reset `busy`, `test_pass` and `test_fail` are 0, `fail_pattern` and `fail_readback` are 0, `geo_abits` is 12, `geo_banks` is 1 and `mem_bytes` is 2^26.
- R2: A test writes and then reads back, at one address, the bytes 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03 in that order, each write followed directly by its read.
- R3: A test stops at the first read that differs from the pattern just written. It sets `test_fail`, places that pattern in `fail_pattern` and the byte read in `fail_readback`, and issues no further access.
- R4: `test_pass` is set, with `fail_pattern` and `fail_readback` at 0, only when all eight read-backs match, which takes exactly 16 accesses.
- R5: With width w, an address splits into row = (addr >> w) & (2^w-1) and column = addr & (2^w-1). The second bank is selected (`mem_bank`=1) when any address bit at position 2w or above is set. A test uses the width held in `geo_abits`.
- R6: Detection begins with w = 12 and probes address 2^(2w)-1 at width w. After each failed probe it lowers w by one and probes again, stopping at the first passing probe.
- R7: When probes at widths 12 down to 9 all fail, width 8 is taken without a probe.
- R8: After the width is settled, detection probes the address one above the last probed address. `geo_banks` becomes 2 if that probe passes and 1 if it fails.
- R9: `mem_bytes` equals 2^(2*geo_abits) * 4 * geo_banks.
- R10: `busy` rises in the cycle after an accepted command and falls when that command's results are written. Commands arriving while `busy` is high are ignored. When both commands arrive together, detection runs and the test command is dropped.
- R11: An access request keeps its write flag, bank, row, column and write data stable until acknowledged, and a new engine run starts only when the engine is idle.
- R12: Test and geometry results stay unchanged while no command is accepted. Any accepted command clears `test_pass` and `test_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_go | input | 1 | Start single-address pattern test |
| test_addr | input | 25 | Byte address to test |
| detect_go | input | 1 | Start geometry detection |
| busy | output | 1 | Command in progress |
| test_pass | output | 1 | Last test matched all patterns |
| test_fail | output | 1 | Last test found a mismatch |
| fail_pattern | output | 8 | Pattern that mismatched |
| fail_readback | output | 8 | Byte read at the mismatch |
| geo_abits | output | 4 | Detected row/column width |
| geo_banks | output | 2 | Detected bank count (1 or 2) |
| mem_bytes | output | 28 | Module size in bytes |
| mem_req | output | 1 | Access request to sequencer |
| mem_we | output | 1 | Access is a write |
| mem_bank | output | 1 | Second bank selected |
| mem_row | output | 12 | Row address |
| mem_col | output | 12 | Column address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Sequencer finished the access |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |

## Verification
`busy` is due high one cycle after the accepting edge, and the bench samples it at the following falling edge. The test and detect results are due in the cycle `busy` falls; their time depends on how quickly the sequencer acknowledges. So the bench polls `busy` at falling edges under a bounded wait, then reads every result at once, and counts the logged accesses against the figure its model predicts. The access log is recorded at the acknowledging edge, which lets the bench check the order of patterns and the address split independently of latency.

// File: rtl/dgp_pkg.sv
package dgp_pkg;
  localparam int BYTE_W = 8;
  localparam int PAT_N  = 8;
  localparam int PIDX_W = $clog2(PAT_N);

  typedef enum logic [1:0] {EN_IDLE, EN_WR, EN_RD} eng_st_t;
  typedef enum logic [2:0] {DT_IDLE, DT_WPROBE, DT_WWAIT, DT_BPROBE, DT_BWAIT} det_st_t;

  // Fixed pattern series; order is part of the behaviour
  function automatic logic [BYTE_W-1:0] pat_at(input logic [PIDX_W-1:0] i);
    case (i)
      3'd0:    pat_at = 8'hF0;
      3'd1:    pat_at = 8'h0F;
      3'd2:    pat_at = 8'hAA;
      3'd3:    pat_at = 8'h55;
      3'd4:    pat_at = 8'hC0;
      3'd5:    pat_at = 8'h30;
      3'd6:    pat_at = 8'h0C;
      default: pat_at = 8'h03;
    endcase
  endfunction
endpackage

// File: rtl/dgp_split.sv
module dgp_split #(
  parameter int MAX_AW = 12,
  parameter int AT_W   = 2*MAX_AW+1,
  parameter int ABW    = $clog2(MAX_AW+1)
) (
  input  logic [AT_W-1:0]   addr,
  input  logic [ABW-1:0]    abits,
  output logic [MAX_AW-1:0] row,
  output logic [MAX_AW-1:0] col,
  output logic              bank
);
  logic [AT_W-1:0] full_mask;
  logic [AT_W-1:0] row_sh;
  logic [AT_W-1:0] hi_sh;

  always_comb begin
    full_mask = (AT_W'(1) << abits) - AT_W'(1);
    row_sh    = (addr >> abits) & full_mask;
    hi_sh     = addr >> {abits, 1'b0};
    row       = row_sh[MAX_AW-1:0];
    col       = addr[MAX_AW-1:0] & full_mask[MAX_AW-1:0];
    bank      = |hi_sh;
  end
endmodule

// File: rtl/dgp_engine.sv
module dgp_engine
  import dgp_pkg::*;
#(
  parameter int MAX_AW = 12,
  parameter int AT_W   = 2*MAX_AW+1,
  parameter int ABW    = $clog2(MAX_AW+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AT_W-1:0]   addr,
  input  logic [ABW-1:0]    abits,
  output logic              done,
  output logic              pass,
  output logic [BYTE_W-1:0] bad_pat,
  output logic [BYTE_W-1:0] bad_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [MAX_AW-1:0] mem_row,
  output logic [MAX_AW-1:0] mem_col,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata
);
  eng_st_t             st_q, st_d;
  logic [PIDX_W-1:0]   idx_q, idx_d;
  logic [AT_W-1:0]     addr_q, addr_d;
  logic [ABW-1:0]      aw_q, aw_d;
  logic                done_d, pass_d;
  logic [BYTE_W-1:0]   bpat_d, bdat_d;
  logic [BYTE_W-1:0]   cur_pat;

  assign cur_pat = pat_at(idx_q);

  dgp_split #(.MAX_AW(MAX_AW), .AT_W(AT_W), .ABW(ABW)) u_split (
    .addr(addr_q), .abits(aw_q), .row(mem_row), .col(mem_col), .bank(mem_bank)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    aw_d   = aw_q;
    done_d = 1'b0;
    pass_d = pass;
    bpat_d = bad_pat;
    bdat_d = bad_data;
    case (st_q)
      EN_IDLE: if (start) begin
        addr_d = addr;
        aw_d   = abits;
        idx_d  = '0;
        st_d   = EN_WR;
      end
      EN_WR: if (mem_ack) st_d = EN_RD;
      EN_RD: if (mem_ack) begin
        if (mem_rdata != cur_pat) begin
          done_d = 1'b1;
          pass_d = 1'b0;
          bpat_d = cur_pat;
          bdat_d = mem_rdata;
          st_d   = EN_IDLE;
        end else if (idx_q == PIDX_W'(PAT_N-1)) begin
          done_d = 1'b1;
          pass_d = 1'b1;
          bpat_d = '0;
          bdat_d = '0;
          st_d   = EN_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = EN_WR;
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= EN_IDLE;
      idx_q    <= '0;
      addr_q   <= '0;
      aw_q     <= ABW'(MAX_AW);
      done     <= 1'b0;
      pass     <= 1'b0;
      bad_pat  <= '0;
      bad_data <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      addr_q   <= addr_d;
      aw_q     <= aw_d;
      done     <= done_d;
      pass     <= pass_d;
      bad_pat  <= bpat_d;
      bad_data <= bdat_d;
    end
  end

  assign mem_req   = (st_q != EN_IDLE);
  assign mem_we    = (st_q == EN_WR);
  assign mem_wdata = cur_pat;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_bank) &&
      $stable(mem_row) && $stable(mem_col) && $stable(mem_wdata))); // R11
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == EN_IDLE)); // R11
  AST_WR_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we && $stable(mem_wdata))); // R2
endmodule

// File: rtl/dgp_detect.sv
module dgp_detect
  import dgp_pkg::*;
#(
  parameter int MAX_AW = 12,
  parameter int MIN_AW = 8,
  parameter int AT_W   = 2*MAX_AW+1,
  parameter int ABW    = $clog2(MAX_AW+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            eng_done,
  input  logic            eng_pass,
  output logic            eng_go,
  output logic [AT_W-1:0] eng_addr,
  output logic [ABW-1:0]  eng_abits,
  output logic            fin,
  output logic [ABW-1:0]  fin_abits,
  output logic            fin_two
);
  det_st_t         st_q, st_d;
  logic [ABW-1:0]  aw_q, aw_d;
  logic [AT_W-1:0] last_q, last_d;
  logic            fin_d, two_d;
  logic [AT_W-1:0] top_addr;

  assign top_addr = (AT_W'(1) << {aw_q, 1'b0}) - AT_W'(1);

  always_comb begin
    st_d   = st_q;
    aw_d   = aw_q;
    last_d = last_q;
    fin_d  = 1'b0;
    two_d  = fin_two;
    case (st_q)
      DT_IDLE: if (start) begin
        aw_d = ABW'(MAX_AW);
        st_d = DT_WPROBE;
      end
      DT_WPROBE: begin
        last_d = top_addr;
        st_d   = DT_WWAIT;
      end
      DT_WWAIT: if (eng_done) begin
        if (eng_pass) begin
          st_d = DT_BPROBE;
        end else if (aw_q == ABW'(MIN_AW+1)) begin
          aw_d = ABW'(MIN_AW);
          st_d = DT_BPROBE;
        end else begin
          aw_d = aw_q - 1'b1;
          st_d = DT_WPROBE;
        end
      end
      DT_BPROBE: st_d = DT_BWAIT;
      DT_BWAIT: if (eng_done) begin
        fin_d = 1'b1;
        two_d = eng_pass;
        st_d  = DT_IDLE;
      end
      default: st_d = DT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DT_IDLE;
      aw_q    <= ABW'(MAX_AW);
      last_q  <= '0;
      fin     <= 1'b0;
      fin_two <= 1'b0;
    end else begin
      st_q    <= st_d;
      aw_q    <= aw_d;
      last_q  <= last_d;
      fin     <= fin_d;
      fin_two <= two_d;
    end
  end

  assign eng_go    = (st_q == DT_WPROBE) || (st_q == DT_BPROBE);
  assign eng_addr  = (st_q == DT_BPROBE) ? (last_q + AT_W'(1)) : top_addr;
  assign eng_abits = aw_q;
  assign fin_abits = aw_q;

  AST_AW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_q >= ABW'(MIN_AW)) && (aw_q <= ABW'(MAX_AW))); // R7
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DT_WWAIT && eng_done && !eng_pass) |=> (aw_q == $past(aw_q) - 1'b1)); // R6
endmodule

// File: rtl/dram_geom_probe.sv
module dram_geom_probe
  import dgp_pkg::*;
#(
  parameter int MAX_AW = 12,
  parameter int MIN_AW = 8,
  localparam int AT_W  = 2*MAX_AW+1,
  localparam int ABW   = $clog2(MAX_AW+1),
  localparam int SZ_W  = 2*MAX_AW+4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_go,
  input  logic [AT_W-1:0]   test_addr,
  input  logic              detect_go,
  output logic              busy,
  output logic              test_pass,
  output logic              test_fail,
  output logic [BYTE_W-1:0] fail_pattern,
  output logic [BYTE_W-1:0] fail_readback,
  output logic [ABW-1:0]    geo_abits,
  output logic [1:0]        geo_banks,
  output logic [SZ_W-1:0]   mem_bytes,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [MAX_AW-1:0] mem_row,
  output logic [MAX_AW-1:0] mem_col,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [1:0] rs_q;
  logic       rsn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rsn = rs_q[1];

  logic              test_acc, det_acc;
  logic              eng_start, eng_done, eng_pass;
  logic [AT_W-1:0]   eng_addr_in;
  logic [ABW-1:0]    eng_aw_in;
  logic [BYTE_W-1:0] eng_bpat, eng_bdat;
  logic              det_go, det_fin, det_two;
  logic [AT_W-1:0]   det_addr;
  logic [ABW-1:0]    det_aw, det_fin_aw;
  logic              run_q, run_d, busy_d, pass_d, fail_d, two_q, two_d;
  logic [BYTE_W-1:0] fpat_d, fdat_d;
  logic [ABW-1:0]    aw_q, aw_d;
  logic [ABW+1:0]    size_sh;

  assign det_acc     = detect_go && !busy;
  assign test_acc    = test_go && !detect_go && !busy;
  assign eng_start   = test_acc || det_go;
  assign eng_addr_in = test_acc ? test_addr : det_addr;
  assign eng_aw_in   = test_acc ? aw_q : det_aw;

  dgp_engine #(.MAX_AW(MAX_AW), .AT_W(AT_W), .ABW(ABW)) u_engine (
    .clk(clk), .rst_n(rsn), .start(eng_start), .addr(eng_addr_in), .abits(eng_aw_in),
    .done(eng_done), .pass(eng_pass), .bad_pat(eng_bpat), .bad_data(eng_bdat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_row(mem_row),
    .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  dgp_detect #(.MAX_AW(MAX_AW), .MIN_AW(MIN_AW), .AT_W(AT_W), .ABW(ABW)) u_detect (
    .clk(clk), .rst_n(rsn), .start(det_acc), .eng_done(eng_done), .eng_pass(eng_pass),
    .eng_go(det_go), .eng_addr(det_addr), .eng_abits(det_aw),
    .fin(det_fin), .fin_abits(det_fin_aw), .fin_two(det_two)
  );

  always_comb begin
    run_d  = run_q;
    busy_d = busy;
    pass_d = test_pass;
    fail_d = test_fail;
    fpat_d = fail_pattern;
    fdat_d = fail_readback;
    aw_d   = aw_q;
    two_d  = two_q;
    if (test_acc || det_acc) begin
      busy_d = 1'b1;
      pass_d = 1'b0;
      fail_d = 1'b0;
      run_d  = test_acc;
    end else if (run_q && eng_done) begin
      busy_d = 1'b0;
      run_d  = 1'b0;
      pass_d = eng_pass;
      fail_d = !eng_pass;
      fpat_d = eng_bpat;
      fdat_d = eng_bdat;
    end else if (det_fin) begin
      busy_d = 1'b0;
      aw_d   = det_fin_aw;
      two_d  = det_two;
    end
  end

  always_ff @(posedge clk or negedge rsn) begin
    if (!rsn) begin
      run_q         <= 1'b0;
      busy          <= 1'b0;
      test_pass     <= 1'b0;
      test_fail     <= 1'b0;
      fail_pattern  <= '0;
      fail_readback <= '0;
      aw_q          <= ABW'(MAX_AW);
      two_q         <= 1'b0;
    end else begin
      run_q         <= run_d;
      busy          <= busy_d;
      test_pass     <= pass_d;
      test_fail     <= fail_d;
      fail_pattern  <= fpat_d;
      fail_readback <= fdat_d;
      aw_q          <= aw_d;
      two_q         <= two_d;
    end
  end

  assign size_sh   = {1'b0, aw_q, 1'b0} + (ABW+2)'(2) + (ABW+2)'(two_q);
  assign mem_bytes = SZ_W'(1) << size_sh;
  assign geo_abits = aw_q;
  assign geo_banks = two_q ? 2'd2 : 2'd1;

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rsn)
    !busy |-> !mem_req); // R10
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rsn)
    (!busy && !test_go && !detect_go) |=> ($stable(test_pass) && $stable(test_fail) &&
      $stable(fail_pattern) && $stable(geo_abits) && $stable(geo_banks))); // R12
  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rsn)
    !(test_pass && test_fail)); // R4
endmodule

// File: tb/dram_geom_probe_tb.sv
module dram_geom_probe_tb;
  localparam int AT_W = 25;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            test_go, detect_go;
  logic [AT_W-1:0] test_addr;
  logic            busy, test_pass, test_fail;
  logic [7:0]      fail_pattern, fail_readback;
  logic [3:0]      geo_abits;
  logic [1:0]      geo_banks;
  logic [27:0]     mem_bytes;
  logic            mem_req, mem_we, mem_bank, mem_ack;
  logic [11:0]     mem_row, mem_col;
  logic [7:0]      mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  dram_geom_probe u_dut (
    .clk(clk), .rst_n(rst_n), .test_go(test_go), .test_addr(test_addr), .detect_go(detect_go),
    .busy(busy), .test_pass(test_pass), .test_fail(test_fail), .fail_pattern(fail_pattern),
    .fail_readback(fail_readback), .geo_abits(geo_abits), .geo_banks(geo_banks),
    .mem_bytes(mem_bytes), .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errs   = 0;
  bit ended  = 0;

  // device model
  int          dev_aw  = 12;
  bit          dev_two = 0;
  bit          flt_on  = 0;
  logic [24:0] flt_key;
  logic [7:0]  flt_and, flt_or;
  logic [7:0]  store [logic [24:0]];

  // access log
  bit          lg_we   [64];
  logic        lg_bank [64];
  logic [11:0] lg_row  [64];
  logic [11:0] lg_col  [64];
  logic [7:0]  lg_dat  [64];
  int          lg_n = 0;

  function automatic bit fits(logic b, logic [11:0] r, logic [11:0] c);
    return (int'(r) < (1 << dev_aw)) && (int'(c) < (1 << dev_aw)) && (!b || dev_two);
  endfunction

  function automatic logic [7:0] model_read(logic b, logic [11:0] r, logic [11:0] c);
    logic [24:0] k = {b, r, c};
    logic [7:0] v;
    if (!fits(b, r, c)) return 8'h00;
    v = store.exists(k) ? store[k] : 8'h00;
    if (flt_on && k == flt_key) v = (v & flt_and) | flt_or;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (lg_n < 64) begin
          lg_we[lg_n] = mem_we; lg_bank[lg_n] = mem_bank;
          lg_row[lg_n] = mem_row; lg_col[lg_n] = mem_col;
          lg_dat[lg_n] = mem_we ? mem_wdata : model_read(mem_bank, mem_row, mem_col);
        end
        lg_n = lg_n + 1;
        if (mem_we) begin
          if (fits(mem_bank, mem_row, mem_col)) store[{mem_bank, mem_row, mem_col}] = mem_wdata;
        end else begin
          mem_rdata <= model_read(mem_bank, mem_row, mem_col);
        end
      end
    end
  end

  // expectations from the requirements
  function automatic logic [7:0] bpat(int i);
    case (i)
      0: return 8'hF0; 1: return 8'h0F; 2: return 8'hAA; 3: return 8'h55;
      4: return 8'hC0; 5: return 8'h30; 6: return 8'h0C; default: return 8'h03;
    endcase
  endfunction

  function automatic void split(logic [24:0] a, int w, output logic [11:0] r,
                                output logic [11:0] c, output logic b);
    logic [24:0] m = (25'd1 << w) - 25'd1;
    logic [24:0] rr = (a >> w) & m;
    r = rr[11:0];
    c = a[11:0] & m[11:0];
    b = ((a >> (2*w)) != 0);
  endfunction

  // returns failing pattern index or -1
  function automatic int exp_test(logic [24:0] a, int w, output logic [7:0] rd);
    logic [11:0] r, c; logic b; logic [7:0] v;
    split(a, w, r, c, b);
    rd = 8'h00;
    for (int i = 0; i < 8; i++) begin
      v = fits(b, r, c) ? bpat(i) : 8'h00;
      if (fits(b, r, c) && flt_on && {b, r, c} == flt_key) v = (v & flt_and) | flt_or;
      if (v != bpat(i)) begin rd = v; return i; end
    end
    return -1;
  endfunction

  function automatic void exp_detect(output int w, output int banks, output int nacc);
    w = 12; nacc = 0;
    while (w > 8) begin
      if (w <= dev_aw) begin nacc += 16; break; end
      nacc += 2; w--;
    end
    banks = dev_two ? 2 : 1;
    nacc += dev_two ? 16 : 2;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    if (busy) begin
      checks++; errs++;
      $display("FAIL %s busy timeout: actual 1 expected 0", req);
    end
  endtask

  task automatic issue(bit t, bit d, logic [24:0] a, string req);
    @(negedge clk);
    lg_n = 0;
    test_go = t; detect_go = d; test_addr = a;
    @(negedge clk);
    test_go = 0; detect_go = 0;
    chk(req, "busy after command (R10)", busy, 1);
  endtask

  task automatic run_detect(string req);
    int w, b, na;
    exp_detect(w, b, na);
    issue(0, 1, '0, req);
    wait_idle(req);
    chk(req, "geo_abits", geo_abits, w);
    chk(req, "geo_banks (R8)", geo_banks, b);
    chk(req, "access count", lg_n, na);
    chk(req, "mem_bytes (R9)", mem_bytes, (longint'(1) << (2*w)) * 4 * b);
    chk(req, "pass/fail cleared (R12)", {test_pass, test_fail}, 0);
  endtask

  task automatic run_test(logic [24:0] a, string req);
    logic [7:0] rd; int k; logic [11:0] r, c; logic bk;
    k = exp_test(a, int'(geo_abits), rd);
    split(a, int'(geo_abits), r, c, bk);
    issue(1, 0, a, req);
    wait_idle(req);
    chk(req, "access count (R3/R4)", lg_n, (k < 0) ? 16 : 2*(k+1));
    chk("R4", "test_pass", test_pass, k < 0);
    chk("R3", "test_fail", test_fail, k >= 0);
    chk("R3", "fail_pattern", fail_pattern, (k < 0) ? 0 : bpat(k));
    chk("R3", "fail_readback", fail_readback, rd);
    if (lg_n > 0 && lg_n <= 16) begin
      for (int i = 0; i < lg_n; i++) begin
        chk("R2", "write/read alternation", lg_we[i], (i % 2) == 0);
        if (i % 2 == 0) chk("R2", "pattern order", lg_dat[i], bpat(i/2));
        chk("R5", "row/col/bank", {lg_bank[i], lg_row[i], lg_col[i]}, {bk, r, c});
      end
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; test_go = 0; detect_go = 0; test_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "pass/fail", {test_pass, test_fail}, 0);
    chk("R1", "fail fields", {fail_pattern, fail_readback}, 0);
    chk("R1", "geo_abits", geo_abits, 12);
    chk("R1", "geo_banks", geo_banks, 1);
    chk("R1", "mem_bytes", mem_bytes, 28'd1 << 26);

    // R6/R8: 10-bit, two banks
    dev_aw = 10; dev_two = 1;
    run_detect("R6");
    chk("R6", "first probe at width 12", {lg_we[0], lg_bank[0], lg_row[0], lg_col[0]}, {1'b1, 1'b0, 12'hFFF, 12'hFFF});
    chk("R6", "second probe at width 11", {lg_row[2], lg_col[2]}, {12'h7FF, 12'h7FF});
    chk("R8", "bank probe address", {lg_bank[20], lg_row[20], lg_col[20]}, {1'b1, 12'h000, 12'h000});

    // R7: width 8 accepted untested, one bank
    dev_aw = 8; dev_two = 0;
    run_detect("R7");
    begin
      bit probed8 = 0;
      for (int i = 0; i < lg_n && i < 64; i++)
        if (lg_row[i] == 12'h0FF && lg_col[i] == 12'h0FF && !lg_bank[i]) probed8 = 1;
      chk("R7", "no probe at width 8", probed8, 0);
    end

    // R4/R5 pass at several addresses under width 8
    run_test(25'h0001234, "R4");
    run_test(25'h000FFFF, "R5");
    run_test(25'h0010000, "R5"); // bank 2 absent -> fails on first pattern
    chk("R3", "absent bank reads zero", {fail_pattern, fail_readback}, {8'hF0, 8'h00});

    // R3 stuck bit fault
    dev_aw = 12; dev_two = 1;
    run_detect("R8");
    flt_on = 1; flt_key = {1'b0, 12'h003, 12'h456}; flt_and = 8'hF7; flt_or = 8'h00;
    run_test(25'h0003456, "R3");
    chk("R3", "stop at 0x0F", {fail_pattern, fail_readback}, {8'h0F, 8'h07});
    flt_and = 8'hFF; flt_or = 8'h10;
    run_test(25'h0003456, "R3");
    chk("R3", "stop at 0x0F with or", {fail_pattern, fail_readback}, {8'h0F, 8'h1F});
    flt_on = 0;

    // R12 results held
    repeat (20) @(negedge clk);
    chk("R12", "fail held", {test_fail, fail_pattern, fail_readback}, {1'b1, 8'h0F, 8'h1F});

    // R10 command while busy is ignored
    issue(1, 0, 25'h0000100, "R10");
    repeat (5) @(negedge clk);
    detect_go = 1; test_go = 1; test_addr = 25'h0;
    @(negedge clk);
    detect_go = 0; test_go = 0;
    wait_idle("R10");
    chk("R10", "only one test ran", lg_n, 16);
    chk("R10", "test result kept", {test_pass, test_fail}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R10", "no late start", busy, 0);

    // R10 simultaneous: detect wins
    dev_aw = 11; dev_two = 0;
    issue(1, 1, 25'h0000001, "R10");
    wait_idle("R10");
    chk("R10", "detect won", geo_abits, 11);
    chk("R10", "test dropped", {test_pass, test_fail}, 0);
    chk("R10", "detect access count", lg_n, 2 + 16 + 2);

    // random geometries and addresses
    for (int it = 0; it < 20; it++) begin
      dev_aw = 8 + int'($urandom_range(4));
      dev_two = $urandom_range(1);
      flt_on = 0;
      run_detect("R9");
      for (int j = 0; j < 3; j++) begin
        logic [24:0] a = 25'($urandom);
        if ($urandom_range(1) == 0) a = a & ((25'd1 << (2*dev_aw)) - 25'd1);
        if ($urandom_range(2) == 0) begin
          logic [11:0] r, c; logic b;
          split(a, dev_aw, r, c, b);
          flt_on = 1; flt_key = {b, r, c};
          flt_and = 8'($urandom); flt_or = 8'($urandom) & ~flt_and;
        end else flt_on = 0;
        run_test(a, "R5");
      end
    end

    finish_run();
  end
endmodule